// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Sequencer

This block is the address and control front end of a flow-through synchronous burst SRAM with an 18-bit word and two 9-bit byte lanes. On each rising clock edge it looks at two active-low address strobes. One strobe is meant for a processor and is gated by the first chip enable. The other is meant for a memory controller and always acts. When either strobe starts a cycle, the block registers a 19-bit external address together with the chip-select state. It then presents that address to the array.

After a start, edges with no strobe continue the burst. An active-low advance input steps a 2-bit beat offset. While the advance input is high, the current location is held. The offset is combined with the two low start bits either by addition modulo four or by exclusive-or. The upper 17 address bits never change inside a burst. Every edge also registers a per-lane write mask, taken from a global write enable or from byte-write enables. That mask is forced to zero for a processor-started first beat and whenever the device is not selected.

Top module: `sburst_addr_ctrl`

## Requirements
- R1: An edge with `ctl_strobe_n` low that is not taken by the processor strobe loads `addr_i` into the state, and `arr_addr_o` equals the loaded address after that edge. This holds even when a burst is running.
- R2: When `sel0_n` is high, `cpu_strobe_n` has no effect. `ctl_strobe_n` still starts a cycle, and that cycle shows `sel_o` = 0.
- R3: When `cpu_strobe_n` and `sel0_n` are both low, the processor strobe wins over `ctl_strobe_n`. The address is loaded and the first beat has `bwr_o` = 0 and `wr_o` = 0, whatever the write inputs are.
- R4: `sel_o` becomes 1 after a start edge only if `sel0_n`=0, `sel1`=1 and `sel2_n`=0 at that edge. Otherwise it becomes 0. It keeps its value on edges with no start.
- R5: With `order_i` = 0 at the start edge, the two low address bits at beat k are (start + k) mod 4.
- R6: With `order_i` = 1 at the start edge, the two low address bits at beat k are start XOR k. The order is captured at the start edge and is not affected by later changes of `order_i`.
- R7: On an edge with no start, `adv_n` = 0 steps the beat offset by one. `adv_n` = 1 leaves `arr_addr_o` unchanged. The offset wraps, so the fifth beat equals the first.
- R8: Bits 18..2 of `arr_addr_o` do not change on edges without a start.
- R9: On a write-qualifying edge, `gwe_n` = 0 gives `bwr_o` = 2'b11, regardless of `bwe_n` and `bw_n`.
- R10: On a write-qualifying edge with `gwe_n` = 1 and `bwe_n` = 0, `bwr_o[i]` = !`bw_n[i]`, where bit 0 is lane a and bit 1 is lane b. With both enables high, `bwr_o` = 0. `wr_o` is the OR of `bwr_o`. A write-qualifying edge is either a controller start of a selected cycle or a no-start edge while `sel_o` is 1.
- R11: `bwr_o` is 0 whenever the block is deselected. A synchronous active-high `rst_i` clears `sel_o`, `bwr_o` and `arr_addr_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 19 | External address |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, gated by sel0_n |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| sel0_n | input | 1 | Master chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane byte-write selects, active low (bit 0 lane a) |
| arr_addr_o | output | 19 | Array address |
| sel_o | output | 1 | Device selected for the current cycle |
| wr_o | output | 1 | Current beat is a write |
| bwr_o | output | 2 | Per-lane write strobes |

## Verification
The hardest situation to reach is a controller strobe that lands in the middle of a suspended or advancing burst. It is just as hard to reach one that arrives together with a processor strobe while the master enable toggles. In both cases the outcome depends on the burst state built up over earlier edges. The bench reaches these states by applying every combination of the eleven control inputs in one long sequence, so each combination meets whatever state the previous vectors left behind. A cycle-level model in the bench tracks that state. Directed bursts then walk all four start offsets in both orders, with suspends and a wrap.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_PROC = 2'd1,
        CYC_CTRL = 2'd2
    } cyc_e;
endpackage

// File: rtl/sbc_strobe_dec.sv
module sbc_strobe_dec
    import sbc_pkg::*;
(
    input  logic cpu_strobe_n,
    input  logic ctl_strobe_n,
    input  logic sel0_n,
    input  logic sel1,
    input  logic sel2_n,
    output cyc_e cyc,
    output logic chip_on
);
    logic cpu_go;

    always_comb begin
        // master enable gates only the processor strobe
        cpu_go  = !cpu_strobe_n && !sel0_n;
        chip_on = !sel0_n && sel1 && !sel2_n;
        if (cpu_go)
            cyc = CYC_PROC;
        else if (!ctl_strobe_n)
            cyc = CYC_CTRL;
        else
            cyc = CYC_NONE;
    end
endmodule

// File: rtl/sbc_burst_seq.sv
module sbc_burst_seq #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base,
    input  logic [BURST_W-1:0] ofs,
    input  logic               ilv,
    output logic [BURST_W-1:0] low
);
    always_comb begin
        if (ilv)
            low = base ^ ofs;
        else
            low = base + ofs;
    end
endmodule

// File: rtl/sbc_wr_qual.sv
module sbc_wr_qual #(
    parameter int LANES = 2
) (
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            mask[g] = !gwe_n || (!bwe_n && !bw_n[g]);
        end
    end
endmodule

// File: rtl/sburst_addr_ctrl.sv
module sburst_addr_ctrl
    import sbc_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int LANES   = 2,
    parameter int BURST_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              adv_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              order_i,
    input  logic              gwe_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic              sel_o,
    output logic              wr_o,
    output logic [LANES-1:0]  bwr_o
);
    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [HI_W-1:0]    hi;
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] ofs;
        logic               ilv;
        logic               sel;
        logic [LANES-1:0]   bwr;
    } state_t;

    state_t s_d, s_q;
    cyc_e cyc;
    logic chip_on;
    logic [LANES-1:0] wmask;
    logic [BURST_W-1:0] low;

    sbc_strobe_dec dec_i (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .sel0_n       (sel0_n),
        .sel1         (sel1),
        .sel2_n       (sel2_n),
        .cyc          (cyc),
        .chip_on      (chip_on)
    );

    sbc_wr_qual #(.LANES(LANES)) wq_i (
        .gwe_n (gwe_n),
        .bwe_n (bwe_n),
        .bw_n  (bw_n),
        .mask  (wmask)
    );

    sbc_burst_seq #(.BURST_W(BURST_W)) seq_i (
        .base (s_q.base),
        .ofs  (s_q.ofs),
        .ilv  (s_q.ilv),
        .low  (low)
    );

    always_comb begin
        s_d = s_q;
        unique case (cyc)
            CYC_PROC: begin
                s_d.hi   = addr_i[ADDR_W-1:BURST_W];
                s_d.base = addr_i[BURST_W-1:0];
                s_d.ofs  = '0;
                s_d.ilv  = order_i;
                s_d.sel  = chip_on;
                s_d.bwr  = '0;           // first processor beat is a read
            end
            CYC_CTRL: begin
                s_d.hi   = addr_i[ADDR_W-1:BURST_W];
                s_d.base = addr_i[BURST_W-1:0];
                s_d.ofs  = '0;
                s_d.ilv  = order_i;
                s_d.sel  = chip_on;
                s_d.bwr  = chip_on ? wmask : '0;
            end
            default: begin
                if (!adv_n)
                    s_d.ofs = s_q.ofs + BURST_W'(1);
                s_d.bwr = s_q.sel ? wmask : '0;
            end
        endcase
        if (rst_i)
            s_d = '0;
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign arr_addr_o = {s_q.hi, low};
    assign sel_o      = s_q.sel;
    assign bwr_o      = s_q.bwr;
    assign wr_o       = |s_q.bwr;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int ADDR_W  = 19,
    parameter int LANES   = 2,
    parameter int BURST_W = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              cpu_strobe_n,
    input logic              ctl_strobe_n,
    input logic              adv_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              gwe_n,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic              sel_o,
    input logic              wr_o,
    input logic [LANES-1:0]  bwr_o
);
    logic cpu_take, no_start, chip_all;
    assign cpu_take = !cpu_strobe_n && !sel0_n;
    assign no_start = ctl_strobe_n && !cpu_take;
    assign chip_all = !sel0_n && sel1 && !sel2_n;

    a_r1_ctl_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctl_strobe_n && !cpu_take) |=> (arr_addr_o == $past(addr_i)));

    a_r2_cpu_blocked: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctl_strobe_n && sel0_n) |=> !sel_o);

    a_r3_cpu_first_read: assert property (@(posedge clk_i) disable iff (rst_i)
        cpu_take |=> (bwr_o == '0 && !wr_o));

    a_r7_suspend_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (no_start && adv_n) |=> $stable(arr_addr_o));

    a_r8_upper_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
        no_start |=> (arr_addr_o[ADDR_W-1:BURST_W] == $past(arr_addr_o[ADDR_W-1:BURST_W])));

    a_r9_global_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctl_strobe_n && !cpu_take && chip_all && !gwe_n) |=> (bwr_o == '1));

    a_r11_desel_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_o |-> (bwr_o == '0));
endmodule

bind sburst_addr_ctrl sbc_checker #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .addr_i       (addr_i),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .adv_n        (adv_n),
    .sel0_n       (sel0_n),
    .sel1         (sel1),
    .sel2_n       (sel2_n),
    .gwe_n        (gwe_n),
    .arr_addr_o   (arr_addr_o),
    .sel_o        (sel_o),
    .wr_o         (wr_o),
    .bwr_o        (bwr_o)
);

// File: tb/sburst_addr_ctrl_tb_top.sv
module sburst_addr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic [18:0] addr_i = '0;
    logic        cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, adv_n = 1'b1;
    logic        sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0, order_i = 1'b0;
    logic        gwe_n = 1'b1, bwe_n = 1'b1;
    logic [1:0]  bw_n = 2'b11;
    logic [18:0] arr_addr_o;
    logic        sel_o, wr_o;
    logic [1:0]  bwr_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of the visible state
    logic [16:0] m_hi = '0;
    logic [1:0]  m_base = '0, m_ofs = '0, m_bwr = '0;
    logic        m_ilv = 0, m_sel = 0;

    always #4 clk = ~clk;

    sburst_addr_ctrl dut_i (
        .clk_i(clk), .rst_i(rst_i), .addr_i(addr_i),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .order_i(order_i),
        .gwe_n(gwe_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .arr_addr_o(arr_addr_o), .sel_o(sel_o), .wr_o(wr_o), .bwr_o(bwr_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic p_go, c_go, csel;
        logic [1:0] we;
        if (rst_i) begin
            m_hi = '0; m_base = '0; m_ofs = '0; m_ilv = 0; m_sel = 0; m_bwr = '0;
        end else begin
            p_go = !cpu_strobe_n && !sel0_n;
            c_go = !ctl_strobe_n && !p_go;
            csel = !sel0_n && sel1 && !sel2_n;
            we   = !gwe_n ? 2'b11 : (!bwe_n ? ~bw_n : 2'b00);
            if (p_go || c_go) begin
                m_hi = addr_i[18:2]; m_base = addr_i[1:0]; m_ofs = 0;
                m_ilv = order_i; m_sel = csel;
                m_bwr = (p_go || !csel) ? 2'b00 : we;
            end else begin
                if (!adv_n) m_ofs = m_ofs + 2'd1;
                m_bwr = m_sel ? we : 2'b00;
            end
        end
    endtask

    function automatic logic [18:0] m_addr();
        return {m_hi, m_ilv ? (m_base ^ m_ofs) : (m_base + m_ofs)};
    endfunction

    // inputs are set at a falling edge; outputs are compared at the next falling edge
    task automatic step_cmp(string ta, string ts, string tw);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(ta, 32'(arr_addr_o), 32'(m_addr()));
        check(ts, 32'(sel_o), 32'(m_sel));
        check(tw, 32'(bwr_o), 32'(m_bwr));
        check(tw, 32'(wr_o), 32'(|m_bwr));
    endtask

    task automatic idle();
        cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1;
        sel0_n = 0; sel1 = 1; sel2_n = 0; gwe_n = 1; bwe_n = 1; bw_n = 2'b11;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
    end

    initial begin
        logic [1:0] lo;
        @(negedge clk);
        step_cmp("R11 reset addr", "R11 reset sel", "R11 reset bwr");
        rst_i = 0;
        // exhaustive control sweep, state carried from vector to vector
        for (int v = 0; v < 4096; v++) begin
            logic [11:0] b;
            b = 12'(v ^ (v >> 3));
            ctl_strobe_n = b[0]; cpu_strobe_n = b[1]; adv_n = b[2];
            sel0_n = b[3]; sel1 = b[4]; sel2_n = b[5]; order_i = b[6];
            gwe_n = b[7]; bwe_n = b[8]; bw_n = b[10:9];
            addr_i = 19'(v * 40503);
            step_cmp("R1 R5 R6 R7 sweep addr", "R2 R4 sweep sel", "R3 R9 R10 R11 sweep bwr");
        end
        // directed bursts: every start offset, both orders, suspend and wrap
        for (int ord = 0; ord < 2; ord++) begin
            for (int st = 0; st < 4; st++) begin
                idle();
                order_i = 1'(ord);
                addr_i = {17'h1A5C3, 2'(st)};
                ctl_strobe_n = 0;
                step_cmp("R1 load", "R4 select", "R10 no write");
                ctl_strobe_n = 1;
                order_i = !order_i;   // later changes must not matter (R6)
                for (int k = 1; k <= 4; k++) begin
                    adv_n = 0;
                    @(posedge clk); model_step(); @(negedge clk);
                    lo = ord ? (2'(st) ^ 2'(k)) : (2'(st) + 2'(k));
                    check(ord ? "R6 interleave beat" : "R5 linear beat", 32'(arr_addr_o), 32'({17'h1A5C3, lo}));
                    check("R8 upper bits", 32'(arr_addr_o[18:2]), 32'h1A5C3);
                    adv_n = 1;
                    @(posedge clk); model_step(); @(negedge clk);
                    check("R7 suspend", 32'(arr_addr_o), 32'({17'h1A5C3, lo}));
                end
                check("R7 wrap", 32'(arr_addr_o[1:0]), 32'(st));
            end
        end
        // mid-burst controller reload
        idle(); addr_i = 19'h00010; ctl_strobe_n = 0;
        step_cmp("R1 a", "R4 a", "R10 a");
        ctl_strobe_n = 1; adv_n = 0;
        step_cmp("R7 a", "R4 b", "R10 b");
        addr_i = 19'h7FFFE; ctl_strobe_n = 0;
        step_cmp("R1 reload", "R4 c", "R10 c");
        check("R1 reload value", 32'(arr_addr_o), 32'h7FFFE);
        // processor strobe blocked by master enable, controller deselects
        idle(); sel0_n = 1; cpu_strobe_n = 0; ctl_strobe_n = 1; addr_i = 19'h12345;
        step_cmp("R2 ignored addr", "R2 ignored sel", "R2 ignored bwr");
        check("R2 no load", 32'(arr_addr_o == 19'h12345), 0);
        ctl_strobe_n = 0; gwe_n = 0;
        step_cmp("R2 ctl addr", "R2 ctl sel", "R11 desel bwr");
        check("R2 deselect", 32'(sel_o), 0);
        // priority and first-beat read
        idle(); cpu_strobe_n = 0; ctl_strobe_n = 0; gwe_n = 0; addr_i = 19'h0ABCD;
        step_cmp("R3 addr", "R3 sel", "R3 bwr");
        check("R3 read beat", 32'(bwr_o), 0);
        cpu_strobe_n = 1; ctl_strobe_n = 1;
        step_cmp("R9 cont addr", "R9 cont sel", "R9 cont bwr");
        check("R9 global", 32'(bwr_o), 3);
        gwe_n = 1; bwe_n = 0; bw_n = 2'b10;
        step_cmp("R10 addr", "R10 sel", "R10 lane a");
        check("R10 lane a only", 32'(bwr_o), 1);
        // reset mid-burst
        rst_i = 1;
        step_cmp("R11 rst addr", "R11 rst sel", "R11 rst bwr");
        check("R11 cleared", 32'({arr_addr_o, sel_o, bwr_o}), 0);
        rst_i = 0;
        done = 1;
    end

    initial begin
        wait (done);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule